// File: doc/BRIEF.md
# Privilege Mode and Exception Sequencer

This block holds the processor's one-bit privilege mode and steps the machine into and out of exception handlers. At each instruction boundary it judges the retiring instruction: a fault it reports, a protected instruction that user mode may not run, a deliberate trap, the privileged return, or the instruction that drops privilege to user mode. It also judges any interrupt that was latched earlier. When an exception is taken, it does four things in one clock edge. It records the resume PC, the mode that was active, whether the cause was a trap, and whether the context may be resumed. It sets kernel mode. It then reads the handler address from a table of 8-byte entries held in memory.

The resume PC depends on the class of the exception. A fault keeps the PC of the failing instruction, so that instruction runs again on return. A trap keeps the PC of the instruction that follows it. An interrupt keeps the PC of the next instruction that has not run. A fault flagged as an abort enters its handler but leaves the saved context marked non-resumable. The privileged return jumps back to the saved PC and restores the saved mode. When the saved cause was a trap, it tells the register file to leave the return-value register alone.

The sequencer has two states. In ST_RUN it evaluates instructions. On a taken exception it moves to ST_FETCH (transition "enter"). In ST_FETCH it holds the table read and ignores instructions. When the read data returns, it issues the redirect and goes back to ST_RUN (transition "dispatch").

Top module: `priv_exc_seq`

## Requirements
- R1: After reset the mode is kernel (kernel_mode=1), busy=0, mem_rd_en=0 and redirect_valid=0.
- R2: An instruction of class 1 (protected op), 3 (return) or 4 (drop privilege) that retires in user mode takes vector 6, and its own cur_pc is saved as the resume PC.
- R3: A retiring instruction with fault_req takes the vector on fault_vec and saves cur_pc. A fault wins over a trap class on the same instruction.
- R4: A class 2 (trap) instruction takes the vector on trap_vec and saves next_pc.
- R5: In the cycle after an exception is taken: kernel_mode=1, busy=1, mem_rd_en=1 and mem_addr = tbl_base + vector*8.
- R6: In ST_FETCH, in the cycle where mem_rd_valid is high, redirect_valid=1 and redirect_pc=mem_rd_data. In the cycle after that, busy=0.
- R7: A class 3 return in kernel mode with a resumable context raises redirect_valid in the same cycle, with redirect_pc equal to the saved PC and keep_rv=1 exactly when the saved cause was a trap. In the next cycle the mode is the saved mode.
- R8: A class 4 instruction in kernel mode gives user mode in the next cycle and no redirect.
- R9: After an abort (fault_req with fault_abort), a return issues no redirect. It instead takes vector 6, with its own cur_pc saved.
- R10: An irq_req pulse is latched together with irq_vec. The latched interrupt is taken at the next user-mode instruction boundary, and next_pc is saved. It is never taken without a retiring instruction.
- R11: A fault or trap from the retiring instruction beats a pending interrupt. The interrupt stays pending, is masked in kernel mode, and is taken at a later user-mode boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| instr_class | input | 3 | 0 normal, 1 protected op, 2 trap, 3 return, 4 drop privilege |
| fault_req | input | 1 | The retiring instruction faulted |
| fault_abort | input | 1 | The fault cannot be recovered (abort) |
| fault_vec | input | 8 | Vector number of the fault |
| trap_vec | input | 8 | Vector number of the trap instruction |
| irq_req | input | 1 | Asynchronous interrupt request |
| irq_vec | input | 8 | Vector number of the interrupt |
| cur_pc | input | 32 | PC of the retiring instruction |
| next_pc | input | 32 | PC of the instruction that follows it |
| tbl_base | input | 32 | Base address of the handler table |
| mem_rd_en | output | 1 | Table read request |
| mem_addr | output | 32 | Table entry address |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 32 | Handler address read from the table |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | New fetch PC |
| keep_rv | output | 1 | On return, leave the return-value register unchanged |
| kernel_mode | output | 1 | Current mode, 1 = kernel |
| busy | output | 1 | Sequencer is in ST_FETCH; instructions are ignored |

## Verification
An exception taken in cycle T shows up one cycle later, in T+1, as busy, kernel mode and the table read address. The redirect appears in the same cycle as the read data, which the bench memory returns one cycle after the request. busy drops one cycle after the redirect. A return redirects in the same cycle as the instruction, through combinational logic, and its mode change is seen one cycle later. The bench drives inputs on the falling edge. It samples combinational results 1 time unit after driving, and samples registered results on the next falling edge, so each check lands in the cycle it is due.

// File: rtl/priv_seq_pkg.sv
package priv_seq_pkg;
    typedef enum logic [2:0] {
        IC_NORMAL = 3'd0,
        IC_PRIV   = 3'd1,
        IC_TRAP   = 3'd2,
        IC_RETURN = 3'd3,
        IC_DROP   = 3'd4
    } iclass_e;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FETCH = 1'b1
    } seq_state_e;

    localparam int unsigned BAD_INSTR_VEC = 6;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import priv_seq_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int VEC_W = 8
) (
    input  logic             kernel_mode,
    input  logic             instr_valid,
    input  logic [2:0]       instr_class,
    input  logic             fault_req,
    input  logic             fault_abort,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  next_pc,
    input  logic             irq_pend,
    input  logic [VEC_W-1:0] irq_vec_q,
    input  logic             ctx_resumable,
    output logic             take_exc,
    output logic [VEC_W-1:0] exc_vec,
    output logic [PC_W-1:0]  exc_epc,
    output logic             exc_is_trap,
    output logic             exc_resumable,
    output logic             irq_take,
    output logic             do_return,
    output logic             do_drop
);
    iclass_e cls;
    logic    is_protected;

    assign cls          = iclass_e'(instr_class);
    assign is_protected = (cls == IC_PRIV) || (cls == IC_RETURN) || (cls == IC_DROP);

    always_comb begin
        take_exc      = 1'b0;
        exc_vec       = '0;
        exc_epc       = cur_pc;
        exc_is_trap   = 1'b0;
        exc_resumable = 1'b1;
        irq_take      = 1'b0;
        do_return     = 1'b0;
        do_drop       = 1'b0;
        if (instr_valid) begin
            if (fault_req) begin
                take_exc      = 1'b1;
                exc_vec       = fault_vec;
                exc_resumable = !fault_abort;
            end else if (is_protected && !kernel_mode) begin
                take_exc = 1'b1;
                exc_vec  = VEC_W'(BAD_INSTR_VEC);
            end else if (cls == IC_RETURN && !ctx_resumable) begin
                take_exc = 1'b1;
                exc_vec  = VEC_W'(BAD_INSTR_VEC);
            end else if (cls == IC_TRAP) begin
                take_exc    = 1'b1;
                exc_vec     = trap_vec;
                exc_epc     = next_pc;
                exc_is_trap = 1'b1;
            end else if (irq_pend && !kernel_mode) begin
                take_exc = 1'b1;
                irq_take = 1'b1;
                exc_vec  = irq_vec_q;
                exc_epc  = next_pc;
            end else begin
                do_return = (cls == IC_RETURN);
                do_drop   = (cls == IC_DROP);
            end
        end
    end
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic [PC_W-1:0] save_epc,
    input  logic            save_mode,
    input  logic            save_is_trap,
    input  logic            save_resumable,
    output logic [PC_W-1:0] ctx_epc,
    output logic            ctx_mode,
    output logic            ctx_is_trap,
    output logic            ctx_resumable
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_epc       <= '0;
            ctx_mode      <= 1'b0;
            ctx_is_trap   <= 1'b0;
            ctx_resumable <= 1'b0;
        end else if (save) begin
            ctx_epc       <= save_epc;
            ctx_mode      <= save_mode;
            ctx_is_trap   <= save_is_trap;
            ctx_resumable <= save_resumable;
        end
    end
endmodule

// File: rtl/vec_entry_addr.sv
module vec_entry_addr #(
    parameter int PC_W        = 32,
    parameter int VEC_W       = 8,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [PC_W-1:0]  base,
    input  logic [VEC_W-1:0] vec,
    output logic [PC_W-1:0]  addr
);
    localparam int PAD_W = PC_W - VEC_W;
    logic [PC_W-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, vec} << ENTRY_SHIFT;
    assign addr   = base + offset;
endmodule

// File: rtl/priv_exc_seq.sv
module priv_exc_seq
    import priv_seq_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int VEC_W       = 8,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [2:0]       instr_class,
    input  logic             fault_req,
    input  logic             fault_abort,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  next_pc,
    input  logic [PC_W-1:0]  tbl_base,
    output logic             mem_rd_en,
    output logic [PC_W-1:0]  mem_addr,
    input  logic             mem_rd_valid,
    input  logic [PC_W-1:0]  mem_rd_data,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             keep_rv,
    output logic             kernel_mode,
    output logic             busy
);
    seq_state_e       state_q, state_d;
    logic             kernel_q;
    logic [VEC_W-1:0] vec_q;
    logic             irq_pend_q;
    logic [VEC_W-1:0] irq_vec_q;

    logic             take_exc, irq_take, do_return, do_drop;
    logic [VEC_W-1:0] exc_vec;
    logic [PC_W-1:0]  exc_epc;
    logic             exc_is_trap, exc_resumable;
    logic [PC_W-1:0]  ctx_epc;
    logic             ctx_mode, ctx_is_trap, ctx_resumable;
    logic             retire;

    assign retire = instr_valid && (state_q == ST_RUN);

    exc_arbiter #(.PC_W(PC_W), .VEC_W(VEC_W)) u_arb (
        .kernel_mode  (kernel_q),
        .instr_valid  (retire),
        .instr_class  (instr_class),
        .fault_req    (fault_req),
        .fault_abort  (fault_abort),
        .fault_vec    (fault_vec),
        .trap_vec     (trap_vec),
        .cur_pc       (cur_pc),
        .next_pc      (next_pc),
        .irq_pend     (irq_pend_q),
        .irq_vec_q    (irq_vec_q),
        .ctx_resumable(ctx_resumable),
        .take_exc     (take_exc),
        .exc_vec      (exc_vec),
        .exc_epc      (exc_epc),
        .exc_is_trap  (exc_is_trap),
        .exc_resumable(exc_resumable),
        .irq_take     (irq_take),
        .do_return    (do_return),
        .do_drop      (do_drop)
    );

    exc_ctx_regs #(.PC_W(PC_W)) u_ctx (
        .clk           (clk),
        .rst_n         (rst_n),
        .save          (take_exc),
        .save_epc      (exc_epc),
        .save_mode     (kernel_q),
        .save_is_trap  (exc_is_trap),
        .save_resumable(exc_resumable),
        .ctx_epc       (ctx_epc),
        .ctx_mode      (ctx_mode),
        .ctx_is_trap   (ctx_is_trap),
        .ctx_resumable (ctx_resumable)
    );

    vec_entry_addr #(.PC_W(PC_W), .VEC_W(VEC_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
        .base(tbl_base),
        .vec (vec_q),
        .addr(mem_addr)
    );

    // State register together with the mode bit, the latched vector and the pending interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            kernel_q   <= 1'b1;
            vec_q      <= '0;
            irq_pend_q <= 1'b0;
            irq_vec_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_exc) begin
                kernel_q <= 1'b1;
                vec_q    <= exc_vec;
            end else if (do_return) begin
                kernel_q <= ctx_mode;
            end else if (do_drop) begin
                kernel_q <= 1'b0;
            end
            if (irq_take) begin
                irq_pend_q <= 1'b0;
            end else if (irq_req && !irq_pend_q) begin
                irq_pend_q <= 1'b1;
                irq_vec_q  <= irq_vec;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d        = state_q;
        mem_rd_en      = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = ctx_epc;
        keep_rv        = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (take_exc) begin
                    state_d = ST_FETCH;
                end
                redirect_valid = do_return;
                keep_rv        = do_return && ctx_is_trap;
            end
            ST_FETCH: begin
                mem_rd_en   = 1'b1;
                redirect_pc = mem_rd_data;
                if (mem_rd_valid) begin
                    redirect_valid = 1'b1;
                    state_d        = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign kernel_mode = kernel_q;
    assign busy        = (state_q == ST_FETCH);
endmodule

// File: rtl/priv_exc_seq_chk.sv
module priv_exc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [2:0] instr_class,
    input logic       fault_req,
    input logic       mem_rd_en,
    input logic       mem_rd_valid,
    input logic       redirect_valid,
    input logic       keep_rv,
    input logic       kernel_mode,
    input logic       busy
);
    a_r5_fetch_in_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> kernel_mode);

    a_r6_dispatch_ends_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rd_valid) |=> !busy);

    a_r7_keep_only_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        keep_rv |-> (redirect_valid && !busy));

    a_r2_user_priv_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && !kernel_mode && instr_class == 3'd1) |=> (busy && kernel_mode));

    a_r4_trap_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && instr_class == 3'd2) |=> busy);

    a_r8_drop_to_user: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && kernel_mode && instr_class == 3'd4 && !fault_req) |=> !kernel_mode);

    a_r10_no_entry_without_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !busy) |=> !busy);
endmodule

bind priv_exc_seq priv_exc_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_class   (instr_class),
    .fault_req     (fault_req),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_valid  (mem_rd_valid),
    .redirect_valid(redirect_valid),
    .keep_rv       (keep_rv),
    .kernel_mode   (kernel_mode),
    .busy          (busy)
);

// File: tb/tb_priv_exc_seq.sv
module tb_priv_exc_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_class = 3'd0;
    logic        fault_req = 1'b0;
    logic        fault_abort = 1'b0;
    logic [7:0]  fault_vec = '0;
    logic [7:0]  trap_vec = '0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] next_pc = '0;
    logic [31:0] tbl_base = BASE;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        keep_rv;
    logic        kernel_mode;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic        r_valid;
    logic [31:0] r_pc;
    logic        r_keep;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_exc_seq dut (.*);

    // Table memory: answers one cycle after a request with the complement of the address
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en && !mem_rd_valid;
        mem_rd_data  <= ~mem_addr;
    end

    typedef struct packed {
        logic [2:0]  cls;
        logic        flt;
        logic [7:0]  fvec;
        logic [7:0]  tvec;
        logic [31:0] cur;
        logic [31:0] nxt;
        logic        exc;
        logic [7:0]  evec;
        logic [31:0] epc;
        logic        keep;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{3'd0, 1'b1, 8'd0,  8'd0,   32'h100, 32'h104, 1'b1, 8'd0,   32'h100, 1'b0}, // R3 divide fault
        '{3'd2, 1'b0, 8'd0,  8'd128, 32'h200, 32'h204, 1'b1, 8'd128, 32'h204, 1'b1}, // R4 system trap
        '{3'd1, 1'b0, 8'd0,  8'd0,   32'h300, 32'h304, 1'b1, 8'd6,   32'h300, 1'b0}, // R2 protected op
        '{3'd3, 1'b0, 8'd0,  8'd0,   32'h400, 32'h404, 1'b1, 8'd6,   32'h400, 1'b0}, // R2 return in user
        '{3'd4, 1'b0, 8'd0,  8'd0,   32'h500, 32'h504, 1'b1, 8'd6,   32'h500, 1'b0}, // R2 drop in user
        '{3'd2, 1'b1, 8'd14, 8'd128, 32'h600, 32'h604, 1'b1, 8'd14,  32'h600, 1'b0}, // R3 fault beats trap
        '{3'd0, 1'b0, 8'd0,  8'd0,   32'h680, 32'h684, 1'b0, 8'd0,   32'h0,   1'b0}  // plain instruction
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step_instr(input logic [2:0] cls, input logic flt, input logic abrt,
                              input logic [7:0] fv, input logic [7:0] tv,
                              input logic [31:0] cpc, input logic [31:0] npc);
        instr_valid = 1'b1; instr_class = cls; fault_req = flt; fault_abort = abrt;
        fault_vec = fv; trap_vec = tv; cur_pc = cpc; next_pc = npc;
        #1;
        r_valid = redirect_valid; r_pc = redirect_pc; r_keep = keep_rv;
        @(negedge clk);
        instr_valid = 1'b0; fault_req = 1'b0; fault_abort = 1'b0;
    endtask

    task automatic expect_entry(input string req, input logic [7:0] v);
        logic [31:0] a;
        a = BASE + {21'd0, v, 3'd0};
        chk({req, " busy"}, 32'(busy), 32'd1);
        chk({req, " kernel"}, 32'(kernel_mode), 32'd1);
        chk({req, " rd_en"}, 32'(mem_rd_en), 32'd1);
        chk({req, " addr"}, mem_addr, a);
        @(negedge clk);
        chk({req, " R6 redirect_valid"}, 32'(redirect_valid), 32'd1);
        chk({req, " R6 redirect_pc"}, redirect_pc, ~a);
        @(negedge clk);
        chk({req, " R6 busy clear"}, 32'(busy), 32'd0);
    endtask

    task automatic do_ret(input string req, input logic [31:0] epc, input logic keep);
        step_instr(3'd3, 1'b0, 1'b0, 8'd0, 8'd0, 32'hF00, 32'hF04);
        chk({req, " R7 ret valid"}, 32'(r_valid), 32'd1);
        chk({req, " R7 ret pc"}, r_pc, epc);
        chk({req, " R7 keep_rv"}, 32'(r_keep), 32'(keep));
        chk({req, " R7 user after ret"}, 32'(kernel_mode), 32'd0);
    endtask

    task automatic to_user();
        step_instr(3'd4, 1'b0, 1'b0, 8'd0, 8'd0, 32'hE00, 32'hE04);
        chk("R8 drop no redirect", 32'(r_valid), 32'd0);
        chk("R8 user mode", 32'(kernel_mode), 32'd0);
        chk("R8 not busy", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 kernel", 32'(kernel_mode), 32'd1);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 rd_en", 32'(mem_rd_en), 32'd0);
        chk("R1 redirect", 32'(redirect_valid), 32'd0);

        to_user();
        for (int i = 0; i < 7; i++) begin
            step_instr(TBL[i].cls, TBL[i].flt, 1'b0, TBL[i].fvec, TBL[i].tvec, TBL[i].cur, TBL[i].nxt);
            if (TBL[i].exc) begin
                expect_entry($sformatf("R5 vec%0d", i), TBL[i].evec);
                do_ret($sformatf("vec%0d", i), TBL[i].epc, TBL[i].keep);
            end else begin
                chk("R2 plain no entry", 32'(busy), 32'd0);
                chk("R2 plain stays user", 32'(kernel_mode), 32'd0);
            end
        end

        // R9 abort: later return is invalid
        step_instr(3'd0, 1'b1, 1'b1, 8'd8, 8'd0, 32'h900, 32'h904);
        expect_entry("R9 abort entry", 8'd8);
        step_instr(3'd3, 1'b0, 1'b0, 8'd0, 8'd0, 32'hF10, 32'hF14);
        chk("R9 no redirect", 32'(r_valid), 32'd0);
        expect_entry("R9 invalid return", 8'd6);
        to_user();

        // R10 latched interrupt taken at next boundary
        irq_req = 1'b1; irq_vec = 8'd32;
        @(negedge clk);
        irq_req = 1'b0; irq_vec = 8'd0;
        @(negedge clk);
        chk("R10 no entry without instr", 32'(busy), 32'd0);
        step_instr(3'd0, 1'b0, 1'b0, 8'd0, 8'd0, 32'h700, 32'h704);
        expect_entry("R10 irq entry", 8'd32);
        do_ret("R10", 32'h704, 1'b0);

        // R11 fault beats pending interrupt; interrupt held and masked in kernel
        irq_req = 1'b1; irq_vec = 8'd33;
        @(negedge clk);
        irq_req = 1'b0;
        step_instr(3'd0, 1'b1, 1'b0, 8'd14, 8'd0, 32'h800, 32'h804);
        expect_entry("R11 fault first", 8'd14);
        do_ret("R11 masked in kernel", 32'h800, 1'b0);
        step_instr(3'd0, 1'b0, 1'b0, 8'd0, 8'd0, 32'h800, 32'h804);
        expect_entry("R11 held irq", 8'd33);
        do_ret("R11", 32'h804, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule